// File: doc/BRIEF.md
# Code Phase Slew Controller

This block shifts the phase of a spreading-code generator by swallowing code-clock enables. Software writes a slew amount counted in half-chip units. The block waits for the right moment to apply it. It then blocks that many half-chip ticks from reaching the generator, so the code falls behind by the programmed amount. The shift is relative to wherever the code phase currently sits.

While ticks are being swallowed, the correlator's integrate-and-dump accumulators are held in reset. They start collecting again only once the shift has completed. A channel that is held in reset sees no code ticks at all, and its accumulators stay cleared.

The slew is applied at one of two moments:
- If it was armed while the channel was inactive, it is applied at the moment the channel is released.
- If the channel was already running, it is applied at the next dump.

Each write produces exactly one shift.

Top module: `codeSlewCtl`

## Requirements
- R1: After system reset `slewBusy` is 0. While the channel is active and no slew is running, `codeTickOut` equals `codeTickIn` in the same cycle and `accumHold` is 0.
- R2: While `chanRstN` is 0 (channel inactive), `codeTickOut` is 0 and `accumHold` is 1 in the same cycle.
- R3: A write (`slewWrEn`=1) with a nonzero value while `slewBusy` is 0 arms a slew. `slewBusy` reads 1 from the next cycle on. Code ticks keep passing until the slew starts.
- R4: A write of value 0 arms nothing. `slewBusy` stays 0 and code ticks are not affected.
- R5: A slew armed while the channel is inactive starts in the cycle after the first cycle in which `chanRstN` is 1. A dump strobe seen while the channel is inactive does not start it.
- R6: A slew armed while the channel is active starts in the cycle after the next cycle that has `dumpStb`=1. The tick in that dump cycle still passes.
- R7: A running slew of value N suppresses exactly the next N cycles in which `codeTickIn` is 1, counted in half chips. `slewBusy` falls in the cycle after the last suppressed tick, and ticks pass again from then on. This holds up to the largest value of `SLEW_W` bits.
- R8: `accumHold` is 1 in every cycle of a running slew, and returns to 0 with the first cycle after the slew ends.
- R9: A slew is one-shot. Dump strobes after it completes cause no further suppression until a new nonzero write.
- R10: Writes made while `slewBusy` is 1 are ignored. They neither change the running count nor arm another slew.
- R11: Dropping `chanRstN` to 0 during a running slew cancels it, and `slewBusy` is 0 from the next cycle.
- R12: A write and a dump strobe in the same cycle do not start the slew on that dump. The slew waits for the following dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | System reset, active low |
| chanRstN | input | 1 | Channel reset: 0 holds the channel inactive, 1 releases it |
| slewWrEn | input | 1 | Host write strobe for the slew amount |
| slewWrData | input | SLEW_W | Slew amount in half-chip units |
| codeTickIn | input | 1 | Half-chip code-clock enable from the code oscillator |
| dumpStb | input | 1 | Integrate-and-dump strobe |
| codeTickOut | output | 1 | Gated code-clock enable to the code generator |
| accumHold | output | 1 | Hold-reset for the integrate-and-dump accumulators |
| slewBusy | output | 1 | High from arming until the last suppressed tick |

## Verification
Two functions can fall in the same cycle: arming a slew and the dump strobe that would apply it. The bench writes the slew value and pulses the dump on the same edge. It then expects ticks to keep passing with `slewBusy` high, and suppression to begin only after a later dump.

A second overlap has a tick arriving in the very cycle a dump or a channel release triggers the start. That tick must pass, while the next one is swallowed. A cancel by channel reset in the middle of a slew is also driven and judged on `slewBusy` and the gated tick.

// File: rtl/codeSlewPkg.sv
package codeSlewPkg;

  typedef enum logic [1:0] {
    SLEW_IDLE = 2'd0,
    SLEW_PEND = 2'd1,
    SLEW_RUN  = 2'd2
  } slewStateT;

  // control -> datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic inhibit;
  } slewStrobeT;

  // datapath -> control
  typedef struct packed {
    logic relEdge;
    logic cntLast;
    logic wrNonZero;
  } slewStatusT;

endpackage

// File: rtl/codeSlewCtrl.sv
module codeSlewCtrl
  import codeSlewPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanRstN,
  input  logic       slewWrEn,
  input  logic       codeTickIn,
  input  logic       dumpStb,
  input  slewStatusT status,
  output slewStrobeT strobe,
  output logic       busy
);

  slewStateT stateQ, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SLEW_IDLE;
    else       stateQ <= stateNext;
  end

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    unique case (stateQ)
      SLEW_IDLE: begin
        if (slewWrEn && status.wrNonZero) begin
          strobe.loadCnt = 1'b1;
          stateNext      = SLEW_PEND;
        end
      end
      SLEW_PEND: begin
        if (chanRstN && (status.relEdge || dumpStb)) stateNext = SLEW_RUN;
      end
      SLEW_RUN: begin
        strobe.inhibit = 1'b1;
        if (!chanRstN) begin
          stateNext = SLEW_IDLE;
        end else if (codeTickIn) begin
          strobe.decCnt = 1'b1;
          if (status.cntLast) stateNext = SLEW_IDLE;
        end
      end
      default: stateNext = SLEW_IDLE;
    endcase
  end

  assign busy = (stateQ != SLEW_IDLE);

  // R5: a pending slew waits while the channel is inactive
  p_wait_inactive_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SLEW_PEND && !chanRstN) |=> (stateQ == SLEW_PEND));

  // R11: channel reset during a running slew cancels it
  p_cancel_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SLEW_RUN && !chanRstN) |=> !busy);

  // R6: the pending state leaves only towards the running state
  p_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SLEW_PEND && stateNext != SLEW_PEND) |=> (stateQ == SLEW_RUN));

endmodule

// File: rtl/codeSlewDatapath.sv
module codeSlewDatapath
  import codeSlewPkg::*;
#(
  parameter int SLEW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanRstN,
  input  logic              codeTickIn,
  input  logic [SLEW_W-1:0] slewWrData,
  input  slewStrobeT        strobe,
  output slewStatusT        status,
  output logic              codeTickOut,
  output logic              accumHold
);

  localparam logic [SLEW_W-1:0] CNT_ONE = SLEW_W'(1);

  logic [SLEW_W-1:0] cntQ;
  logic              chanPrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ      <= '0;
      chanPrevQ <= 1'b0;
    end else begin
      chanPrevQ <= chanRstN;
      if (strobe.loadCnt)     cntQ <= slewWrData;
      else if (strobe.decCnt) cntQ <= cntQ - CNT_ONE;
    end
  end

  always_comb begin
    status.relEdge   = chanRstN && !chanPrevQ;
    status.cntLast   = (cntQ == CNT_ONE);
    status.wrNonZero = (slewWrData != '0);
  end

  assign codeTickOut = codeTickIn && chanRstN && !strobe.inhibit;
  assign accumHold   = !chanRstN || strobe.inhibit;

  // R10: the count changes only on a load or a counted tick
  p_cnt_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadCnt && !strobe.decCnt) |=> $stable(cntQ));

  // R7: a counted tick never starts from an empty count
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCnt |-> (cntQ != '0));

endmodule

// File: rtl/codeSlewCtl.sv
module codeSlewCtl
  import codeSlewPkg::*;
#(
  parameter int SLEW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanRstN,
  input  logic              slewWrEn,
  input  logic [SLEW_W-1:0] slewWrData,
  input  logic              codeTickIn,
  input  logic              dumpStb,
  output logic              codeTickOut,
  output logic              accumHold,
  output logic              slewBusy
);

  slewStrobeT strobe;
  slewStatusT status;

  codeSlewCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .chanRstN   (chanRstN),
    .slewWrEn   (slewWrEn),
    .codeTickIn (codeTickIn),
    .dumpStb    (dumpStb),
    .status     (status),
    .strobe     (strobe),
    .busy       (slewBusy)
  );

  codeSlewDatapath #(.SLEW_W(SLEW_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .chanRstN    (chanRstN),
    .codeTickIn  (codeTickIn),
    .slewWrData  (slewWrData),
    .strobe      (strobe),
    .status      (status),
    .codeTickOut (codeTickOut),
    .accumHold   (accumHold)
  );

  // R3: a nonzero write while idle arms the slew
  p_arm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!slewBusy && slewWrEn && slewWrData != '0) |=> slewBusy);

  // R4: a zero write while idle arms nothing
  p_zero_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!slewBusy && slewWrEn && slewWrData == '0) |=> !slewBusy);

  // R8: the running slew swallows ticks and holds the accumulators
  p_suppress_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inhibit |-> (!codeTickOut && accumHold));

  // R2: an inactive channel gets no ticks
  p_inactive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !chanRstN |-> (!codeTickOut && accumHold));

  // R7: busy ends only after a swallowed tick or a cancel
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(slewBusy) |-> ($past(codeTickIn) || !$past(chanRstN)));

endmodule

// File: tb/codeSlewCtl_test.sv
module codeSlewCtl_test;

  localparam int CLK_PERIOD = 10;
  localparam int SLEW_W     = 8;
  localparam int MAX_SLEW   = (1 << SLEW_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              chanRstN = 1'b0;
  logic              slewWrEn = 1'b0;
  logic [SLEW_W-1:0] slewWrData = '0;
  logic              codeTickIn = 1'b0;
  logic              dumpStb = 1'b0;
  logic              codeTickOut, accumHold, slewBusy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [2:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  codeSlewCtl #(.SLEW_W(SLEW_W)) uut (
    .clk(clk), .rstN(rstN), .chanRstN(chanRstN), .slewWrEn(slewWrEn),
    .slewWrData(slewWrData), .codeTickIn(codeTickIn), .dumpStb(dumpStb),
    .codeTickOut(codeTickOut), .accumHold(accumHold), .slewBusy(slewBusy)
  );

  task automatic checkBit(input string tag, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus plus the outputs expected in it
  task automatic step(input logic w, input logic [SLEW_W-1:0] d, input logic tk,
                      input logic dp, input logic ch, input logic eTick,
                      input logic eHold, input logic eBusy, input string tag);
    @(negedge clk);
    slewWrEn   = w;
    slewWrData = d;
    codeTickIn = tk;
    dumpStb    = dp;
    chanRstN   = ch;
    expQ.push_back({eTick, eHold, eBusy});
    tagQ.push_back(tag);
  endtask

  // monitor: compares each cycle away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        logic [2:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkBit(t, "codeTickOut", codeTickOut, e[2]);
        checkBit(t, "accumHold",   accumHold,   e[1]);
        checkBit(t, "slewBusy",    slewBusy,    e[0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset state (R1) with the channel inactive (R2)
    step(0, 0, 1, 0, 0, 0, 1, 0, "R1");
    step(0, 0, 1, 0, 0, 0, 1, 0, "R1");
    @(negedge clk); rstN = 1'b1;
    step(0, 0, 1, 0, 0, 0, 1, 0, "R2");
    step(0, 0, 1, 1, 0, 0, 1, 0, "R2");
    // release with nothing armed: ticks pass
    step(0, 0, 1, 0, 1, 1, 0, 0, "R1");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R1");
    // zero write arms nothing
    step(1, 0, 1, 0, 1, 1, 0, 0, "R4");
    step(0, 0, 1, 0, 1, 1, 0, 0, "R4");
    step(0, 0, 1, 1, 1, 1, 0, 0, "R4");
    step(0, 0, 1, 0, 1, 1, 0, 0, "R4");
    // active channel: slew of 3 applied after the next dump
    step(1, 3, 0, 0, 1, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 1, 1, 0, 1, "R3");
    step(0, 0, 1, 1, 1, 1, 0, 1, "R6");
    step(0, 0, 1, 0, 1, 0, 1, 1, "R7");
    step(0, 0, 0, 0, 1, 0, 1, 1, "R8");
    step(1, 5, 1, 0, 1, 0, 1, 1, "R10");
    step(0, 0, 1, 0, 1, 0, 1, 1, "R7");
    step(0, 0, 1, 0, 1, 1, 0, 0, "R7");
    step(0, 0, 1, 1, 1, 1, 0, 0, "R9");
    step(0, 0, 1, 0, 1, 1, 0, 0, "R9");
    step(0, 0, 1, 1, 1, 1, 0, 0, "R10");
    step(0, 0, 1, 0, 1, 1, 0, 0, "R10");
    // write and dump in the same cycle
    step(1, 2, 1, 1, 1, 1, 0, 0, "R12");
    step(0, 0, 1, 0, 1, 1, 0, 1, "R12");
    step(0, 0, 1, 0, 1, 1, 0, 1, "R12");
    step(0, 0, 0, 1, 1, 0, 0, 1, "R6");
    step(0, 0, 1, 0, 1, 0, 1, 1, "R12");
    step(0, 0, 1, 0, 1, 0, 1, 1, "R12");
    step(0, 0, 1, 0, 1, 1, 0, 0, "R12");
    // armed while inactive: applied at release
    step(0, 0, 1, 0, 0, 0, 1, 0, "R2");
    step(1, 1, 1, 0, 0, 0, 1, 0, "R5");
    step(0, 0, 1, 1, 0, 0, 1, 1, "R5");
    step(0, 0, 1, 0, 0, 0, 1, 1, "R5");
    step(0, 0, 1, 0, 1, 1, 0, 1, "R5");
    step(0, 0, 1, 0, 1, 0, 1, 1, "R5");
    step(0, 0, 1, 0, 1, 1, 0, 0, "R5");
    // cancel by channel reset mid-slew
    step(1, 4, 0, 0, 1, 0, 0, 0, "R11");
    step(0, 0, 0, 1, 1, 0, 0, 1, "R11");
    step(0, 0, 1, 0, 1, 0, 1, 1, "R11");
    step(0, 0, 1, 0, 0, 0, 1, 1, "R11");
    step(0, 0, 1, 0, 0, 0, 1, 0, "R11");
    step(0, 0, 1, 0, 1, 1, 0, 0, "R11");
    step(0, 0, 1, 1, 1, 1, 0, 0, "R11");
    // largest slew value
    step(1, SLEW_W'(MAX_SLEW), 1, 0, 1, 1, 0, 0, "R7");
    step(0, 0, 1, 1, 1, 1, 0, 1, "R7");
    for (int i = 0; i < MAX_SLEW; i++) step(0, 0, 1, 0, 1, 0, 1, 1, "R7");
    step(0, 0, 1, 0, 1, 1, 0, 0, "R7");
    step(0, 0, 1, 1, 1, 1, 0, 0, "R9");
    step(0, 0, 1, 0, 1, 1, 0, 0, "R9");
    // drain
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule